// File: doc/BRIEF.md
# Variable-Page-Size Associative TLB

This block translates virtual addresses through a fully associative table of 64 entries. Each entry stores a virtual page tag with a 13-bit context and a translation word. The translation word carries a valid flag, a page-size code, global, privileged, writable, no-fault-only, side-effect and used flags, and a physical page number. Every entry compares the lookup address under the mask that its own page size selects. The same table therefore serves pages of 8 KB, 64 KB, 512 KB and 4 MB. A global entry ignores the context.

A lookup presents a virtual address, an access kind (fetch, load, store or no-fault load), a context select and a user flag. One cycle later the block answers with exactly one outcome:
- a hit, with a physical address and a write permission;
- a fault, with cause bits;
- a miss.

The block also holds three registers that trap handling reads: a tag-access register, a fault status register and a fault address register. Entries are loaded through an indexed write port. A combinational probe port reads back the translation word of any entry. When translation is disabled, the address passes straight through.

Top module: `tlb_xlate`

## Requirements
- R1: A request sampled with req_valid_i at a rising edge produces rsp_valid_o in the following cycle. In that cycle exactly one of rsp_hit_o, rsp_miss_o and rsp_fault_o is 1. Without a request all response outputs are 0, and after reset every output is 0.
- R2: When wr_en_i is high, the edge writes wr_vpn_i (VA bits 63:13), wr_ctx_i and wr_data_i into entry wr_idx_i. The layout of wr_data_i is: bit 36 valid, 35:34 size, 33 global, 32 privileged, 31 writable, 30 no-fault-only, 29 side-effect, 28 used, 27:0 physical page (PA bits 40:13). A lookup in the same cycle as the write still sees the old contents; the next lookup sees the new ones.
- R3: Size codes 0, 1, 2 and 3 ignore VA bits below 13, 16, 19 and 22. On a hit, rsp_pa_o bits 40:13 take the page bits from the entry above the mask and from the VA below the mask. rsp_pa_o bits 12:0 are 0.
- R4: An entry matches when it is valid, its masked tag equals the masked VA, and it is either global or holds the lookup context. The lookup context is prim_ctx_i for select 0, sec_ctx_i for select 1, and 0 (nucleus) for selects 2 and 3.
- R5: When several entries match, the entry with the lowest index gives the result.
- R6: The cause bits in rsp_cause_o are: bit 0 for a user access to a privileged entry, bit 1 for a no-fault load (kind 3) to a side-effect entry, and bit 2 for a load (kind 1) or store (kind 2) to a no-fault-only entry. A fetch (kind 0) can only raise bit 0. Any set cause gives a fault, and several causes may be set together.
- R7: A store to a non-writable entry that raises no cause gives a fault with rsp_prot_o=1 and rsp_cause_o=0. A clean hit on a data access reports rsp_wr_o equal to the writable flag; a fetch reports rsp_wr_o=0.
- R8: A hit without a fault sets the used flag of the winning entry, as read back on probe_data_o. A write to the same entry in the same cycle takes precedence over setting the flag.
- R9: On a fault or a miss, tag_access_o is loaded with VA bits 63:13 above the 13-bit lookup context.
- R10: A miss leaves fsr_o and far_o unchanged.
- R11: On a fault, far_o is loaded with the VA. fsr_o is rewritten with these fields:
  - bit 0 valid (1);
  - bit 1 overflow, equal to the previous valid bit;
  - bit 2 privileged mode (not user);
  - bit 3 store;
  - bit 4 no-fault load;
  - bits 6:5 context type (0 primary, 1 secondary, 2 nucleus);
  - bits 9:7 the cause bits of R6.

  fsr_clr_i clears fsr_o; if it coincides with a fault, it acts before the overflow bit is formed.
- R12: With xlate_en_i low, a request hits and gives rsp_pa_o equal to VA bits 40:0, with rsp_wr_o=1 for data kinds. The table, tag_access_o, fsr_o and far_o are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xlate_en_i | input | 1 | Translation enable |
| prim_ctx_i | input | 13 | Primary context |
| sec_ctx_i | input | 13 | Secondary context |
| req_valid_i | input | 1 | Lookup request |
| req_va_i | input | 64 | Lookup virtual address |
| req_kind_i | input | 2 | 0 fetch, 1 load, 2 store, 3 no-fault load |
| req_ctx_sel_i | input | 2 | 0 primary, 1 secondary, 2/3 nucleus |
| req_user_i | input | 1 | User-mode access |
| wr_en_i | input | 1 | Entry write strobe |
| wr_idx_i | input | 6 | Entry index to write |
| wr_vpn_i | input | 51 | Tag virtual page (VA 63:13) |
| wr_ctx_i | input | 13 | Tag context |
| wr_data_i | input | 37 | Translation word |
| probe_idx_i | input | 6 | Entry index to read back |
| probe_data_o | output | 37 | Translation word of probed entry |
| fsr_clr_i | input | 1 | Clear fault status |
| rsp_valid_o | output | 1 | Response valid |
| rsp_hit_o | output | 1 | Translation hit |
| rsp_miss_o | output | 1 | No entry matched |
| rsp_fault_o | output | 1 | Access fault |
| rsp_prot_o | output | 1 | Write protection fault |
| rsp_cause_o | output | 3 | Fault causes |
| rsp_wr_o | output | 1 | Write permitted |
| rsp_pa_o | output | 41 | Physical address |
| tag_access_o | output | 64 | Tag-access register |
| fsr_o | output | 10 | Fault status register |
| far_o | output | 64 | Fault address register |

## Verification
The checker watches on every cycle the one-cycle response timing and the single outcome per response. It also checks that a protection fault never carries a cause bit, that hit addresses are page aligned, that a miss never disturbs the status register, and that a fault always leaves the status valid and flags overflow when an unread status was pending.

Only the bench scenarios can show the rest:
- the numeric results of masking and address composition for each page size;
- the lowest-index choice among overlapping entries;
- context and global matching;
- the used-flag writeback;
- the exact fields written into the tag-access, status and address registers.

The bench compares all of these against a reference model of the table.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W     = 64;
  localparam int PA_W     = 41;
  localparam int CTX_W    = 13;
  localparam int PG_SHIFT = 13;
  localparam int VPN_W    = VA_W - PG_SHIFT;
  localparam int PPN_W    = PA_W - PG_SHIFT;
  localparam int SZ_STEP  = 3;   // mask grows by 3 bits per size code

  typedef enum logic [1:0] {
    KIND_FETCH  = 2'd0,
    KIND_LOAD   = 2'd1,
    KIND_STORE  = 2'd2,
    KIND_NFLOAD = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic             valid;
    logic [1:0]       size;
    logic             glob;
    logic             priv;
    logic             wr_ok;
    logic             nfo;
    logic             side_eff;
    logic             used;
    logic [PPN_W-1:0] ppn;
  } tte_t;

  localparam int TTE_W = $bits(tte_t);

  localparam int FSR_VALID = 0;
  localparam int FSR_OW    = 1;
  localparam int FSR_PM    = 2;
  localparam int FSR_WR    = 3;
  localparam int FSR_NF    = 4;
  localparam int FSR_CT    = 5;
  localparam int FSR_FT    = 7;
  localparam int FSR_W     = 10;
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 64
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [$clog2(N_ENTRIES)-1:0] wr_idx_i,
  input  logic [VPN_W-1:0]             wr_vpn_i,
  input  logic [CTX_W-1:0]             wr_ctx_i,
  input  tte_t                         wr_tte_i,
  input  logic                         set_used_i,
  input  logic [$clog2(N_ENTRIES)-1:0] set_idx_i,
  input  logic [VPN_W-1:0]             lk_vpn_i,
  input  logic [CTX_W-1:0]             lk_ctx_i,
  output logic [N_ENTRIES-1:0]         match_o,
  input  logic [$clog2(N_ENTRIES)-1:0] hit_idx_i,
  output tte_t                         hit_tte_o,
  input  logic [$clog2(N_ENTRIES)-1:0] probe_idx_i,
  output tte_t                         probe_tte_o
);
  localparam int IDX_W = $clog2(N_ENTRIES);

  tte_t             tte_q [N_ENTRIES];
  logic [VPN_W-1:0] vpn_q [N_ENTRIES];
  logic [CTX_W-1:0] ctx_q [N_ENTRIES];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    logic [VPN_W-1:0] vmask;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tte_q[g] <= '0;
        vpn_q[g] <= '0;
        ctx_q[g] <= '0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        tte_q[g] <= wr_tte_i;
        vpn_q[g] <= wr_vpn_i;
        ctx_q[g] <= wr_ctx_i;
      end else if (set_used_i && set_idx_i == IDX_W'(g)) begin
        tte_q[g].used <= 1'b1;
      end
    end

    assign vmask = {VPN_W{1'b1}} << (SZ_STEP * int'(tte_q[g].size));
    assign match_o[g] = tte_q[g].valid
                      && (((lk_vpn_i ^ vpn_q[g]) & vmask) == '0)
                      && (tte_q[g].glob || ctx_q[g] == lk_ctx_i);
  end

  assign hit_tte_o   = tte_q[hit_idx_i];
  assign probe_tte_o = tte_q[probe_idx_i];
endmodule

// File: rtl/tlb_prio_pick.sv
module tlb_prio_pick #(
  parameter int N_ENTRIES = 64
) (
  input  logic [N_ENTRIES-1:0]         req_i,
  output logic                         any_o,
  output logic [$clog2(N_ENTRIES)-1:0] idx_o
);
  localparam int IDX_W = $clog2(N_ENTRIES);

  always_comb begin
    idx_o = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/tlb_status_regs.sv
module tlb_status_regs
  import tlb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tag_upd_i,
  input  logic [VA_W-1:0]  tag_val_i,
  input  logic             fault_i,
  input  logic [FSR_W-1:0] fsr_new_i,
  input  logic [VA_W-1:0]  far_val_i,
  input  logic             clr_i,
  output logic [VA_W-1:0]  tag_access_o,
  output logic [FSR_W-1:0] fsr_o,
  output logic [VA_W-1:0]  far_o
);
  logic [FSR_W-1:0] fsr_base;
  logic [FSR_W-1:0] fsr_ow;

  assign fsr_base = clr_i ? '0 : fsr_o;

  always_comb begin
    fsr_ow         = '0;
    fsr_ow[FSR_OW] = fsr_base[FSR_VALID];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_access_o <= '0;
      fsr_o        <= '0;
      far_o        <= '0;
    end else begin
      if (tag_upd_i) tag_access_o <= tag_val_i;
      if (fault_i) begin
        fsr_o <= fsr_new_i | fsr_ow;
        far_o <= far_val_i;
      end else if (clr_i) begin
        fsr_o <= '0;
      end
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 64,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xlate_en_i,
  input  logic [CTX_W-1:0]  prim_ctx_i,
  input  logic [CTX_W-1:0]  sec_ctx_i,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   req_va_i,
  input  logic [1:0]        req_kind_i,
  input  logic [1:0]        req_ctx_sel_i,
  input  logic              req_user_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [CTX_W-1:0]  wr_ctx_i,
  input  logic [TTE_W-1:0]  wr_data_i,
  input  logic [IDX_W-1:0]  probe_idx_i,
  output logic [TTE_W-1:0]  probe_data_o,
  input  logic              fsr_clr_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_miss_o,
  output logic              rsp_fault_o,
  output logic              rsp_prot_o,
  output logic [2:0]        rsp_cause_o,
  output logic              rsp_wr_o,
  output logic [PA_W-1:0]   rsp_pa_o,
  output logic [VA_W-1:0]   tag_access_o,
  output logic [FSR_W-1:0]  fsr_o,
  output logic [VA_W-1:0]   far_o
);
  acc_kind_e          kind;
  logic [CTX_W-1:0]   lk_ctx;
  logic [1:0]         ctx_type;
  logic [N_ENTRIES-1:0] match;
  logic               any;
  logic [IDX_W-1:0]   hit_idx;
  tte_t               tte_h;
  tte_t               tte_p;
  logic [PPN_W-1:0]   pmask;
  logic [PA_W-1:0]    pa_xl;
  logic               f_priv, f_side, f_nfo, f_prot, flt;
  logic               lk_go, set_used, tag_upd, fault_go;
  logic               hit_d, miss_d, fault_d, wr_d;
  logic [PA_W-1:0]    pa_d;
  logic [FSR_W-1:0]   fsr_new;

  assign kind = acc_kind_e'(req_kind_i);

  always_comb begin
    unique case (req_ctx_sel_i)
      2'd0:    begin lk_ctx = prim_ctx_i; ctx_type = 2'd0; end
      2'd1:    begin lk_ctx = sec_ctx_i;  ctx_type = 2'd1; end
      default: begin lk_ctx = '0;         ctx_type = 2'd2; end
    endcase
  end

  tlb_entry_array #(.N_ENTRIES(N_ENTRIES)) i_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_idx_i    (wr_idx_i),
    .wr_vpn_i    (wr_vpn_i),
    .wr_ctx_i    (wr_ctx_i),
    .wr_tte_i    (tte_t'(wr_data_i)),
    .set_used_i  (set_used),
    .set_idx_i   (hit_idx),
    .lk_vpn_i    (req_va_i[VA_W-1:PG_SHIFT]),
    .lk_ctx_i    (lk_ctx),
    .match_o     (match),
    .hit_idx_i   (hit_idx),
    .hit_tte_o   (tte_h),
    .probe_idx_i (probe_idx_i),
    .probe_tte_o (tte_p)
  );

  assign probe_data_o = tte_p;

  tlb_prio_pick #(.N_ENTRIES(N_ENTRIES)) i_pick (
    .req_i (match),
    .any_o (any),
    .idx_o (hit_idx)
  );

  // page composition under the winner's size mask
  assign pmask = {PPN_W{1'b1}} << (SZ_STEP * int'(tte_h.size));
  assign pa_xl = {(tte_h.ppn & pmask) | (req_va_i[PA_W-1:PG_SHIFT] & ~pmask),
                  {PG_SHIFT{1'b0}}};

  // fault causes, only meaningful with a valid winner
  assign f_priv = any && tte_h.valid && tte_h.priv && req_user_i;
  assign f_side = any && tte_h.valid && kind == KIND_NFLOAD && tte_h.side_eff;
  assign f_nfo  = any && tte_h.valid && (kind == KIND_LOAD || kind == KIND_STORE)
                  && tte_h.nfo;
  assign f_prot = any && tte_h.valid && !(f_priv || f_side || f_nfo)
                  && kind == KIND_STORE && !tte_h.wr_ok;
  assign flt    = f_priv || f_side || f_nfo || f_prot;

  assign lk_go    = req_valid_i && xlate_en_i;
  assign set_used = lk_go && any && !flt && !tte_h.used;
  assign tag_upd  = lk_go && (!any || flt);
  assign fault_go = lk_go && any && flt;

  always_comb begin
    if (!xlate_en_i) begin
      hit_d   = 1'b1;
      miss_d  = 1'b0;
      fault_d = 1'b0;
      wr_d    = kind != KIND_FETCH;
      pa_d    = req_va_i[PA_W-1:0];
    end else begin
      hit_d   = any && !flt;
      miss_d  = !any;
      fault_d = any && flt;
      wr_d    = hit_d && kind != KIND_FETCH && tte_h.wr_ok;
      pa_d    = hit_d ? pa_xl : '0;
    end
  end

  always_comb begin
    fsr_new                     = '0;
    fsr_new[FSR_VALID]          = 1'b1;
    fsr_new[FSR_PM]             = !req_user_i;
    fsr_new[FSR_WR]             = kind == KIND_STORE;
    fsr_new[FSR_NF]             = kind == KIND_NFLOAD;
    fsr_new[FSR_CT+1:FSR_CT]    = ctx_type;
    fsr_new[FSR_FT+2:FSR_FT]    = {f_nfo, f_side, f_priv};
  end

  tlb_status_regs i_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tag_upd_i    (tag_upd),
    .tag_val_i    ({req_va_i[VA_W-1:PG_SHIFT], lk_ctx}),
    .fault_i      (fault_go),
    .fsr_new_i    (fsr_new),
    .far_val_i    (req_va_i),
    .clr_i        (fsr_clr_i),
    .tag_access_o (tag_access_o),
    .fsr_o        (fsr_o),
    .far_o        (far_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_miss_o  <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_prot_o  <= 1'b0;
      rsp_cause_o <= '0;
      rsp_wr_o    <= 1'b0;
      rsp_pa_o    <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_hit_o   <= req_valid_i && hit_d;
      rsp_miss_o  <= req_valid_i && miss_d;
      rsp_fault_o <= req_valid_i && fault_d;
      rsp_prot_o  <= lk_go && f_prot;
      rsp_cause_o <= lk_go ? {f_nfo, f_side, f_priv} : 3'b000;
      rsp_wr_o    <= req_valid_i && wr_d;
      rsp_pa_o    <= req_valid_i ? pa_d : '0;
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
  import tlb_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             xlate_en_i,
  input logic             fsr_clr_i,
  input logic             rsp_valid_o,
  input logic             rsp_hit_o,
  input logic             rsp_miss_o,
  input logic             rsp_fault_o,
  input logic             rsp_prot_o,
  input logic [2:0]       rsp_cause_o,
  input logic [PA_W-1:0]  rsp_pa_o,
  input logic [FSR_W-1:0] fsr_o
);
  a_r1_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  a_r1_no_rsp_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && !rsp_hit_o && !rsp_miss_o && !rsp_fault_o);

  a_r1_single_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $countones({rsp_hit_o, rsp_miss_o, rsp_fault_o}) == 1);

  a_r7_prot_without_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_prot_o |-> rsp_fault_o && rsp_cause_o == 3'b000);

  a_r3_pa_page_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o && $past(xlate_en_i) |-> rsp_pa_o[PG_SHIFT-1:0] == '0);

  a_r10_miss_keeps_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_miss_o && !$past(fsr_clr_i) |-> $stable(fsr_o));

  a_r11_fault_sets_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> fsr_o[FSR_VALID]);

  a_r11_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o && $past(fsr_o[FSR_VALID]) && !$past(fsr_clr_i) |-> fsr_o[FSR_OW]);
endmodule

bind tlb_xlate tlb_xlate_chk i_chk (.*);

// File: tb/test_tlb_xlate.sv
`timescale 1ns/1ps
module test_tlb_xlate;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        xlate_en_i = 1'b0;
  logic [12:0] prim_ctx_i = '0, sec_ctx_i = '0;
  logic        req_valid_i = 1'b0;
  logic [63:0] req_va_i = '0;
  logic [1:0]  req_kind_i = '0, req_ctx_sel_i = '0;
  logic        req_user_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [5:0]  wr_idx_i = '0;
  logic [50:0] wr_vpn_i = '0;
  logic [12:0] wr_ctx_i = '0;
  logic [36:0] wr_data_i = '0;
  logic [5:0]  probe_idx_i = '0;
  logic [36:0] probe_data_o;
  logic        fsr_clr_i = 1'b0;
  logic        rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_fault_o, rsp_prot_o, rsp_wr_o;
  logic [2:0]  rsp_cause_o;
  logic [40:0] rsp_pa_o;
  logic [63:0] tag_access_o, far_o;
  logic [9:0]  fsr_o;

  tlb_xlate i_tlb_xlate (.*);

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [50:0] m_vpn [64];
  logic [12:0] m_ctx [64];
  logic [36:0] m_dat [64];
  logic [63:0] e_tag = '0, e_far = '0;
  logic [9:0]  e_fsr = '0;

  bit          pw_en = 1'b0;
  logic [5:0]  pw_idx;
  logic [50:0] pw_vpn;
  logic [12:0] pw_ctx;
  logic [36:0] pw_dat;

  task automatic check(input string rq, input logic [159:0] act, input logic [159:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [36:0] mk(bit v, logic [1:0] sz, bit g, bit p, bit w,
                                     bit nf, bit se, logic [27:0] ppn);
    return {v, sz, g, p, w, nf, se, 1'b0, ppn};
  endfunction

  task automatic apply_pending();
    if (pw_en) begin
      m_vpn[pw_idx] = pw_vpn;
      m_ctx[pw_idx] = pw_ctx;
      m_dat[pw_idx] = pw_dat;
    end
    pw_en = 1'b0;
  endtask

  task automatic wr_entry(input int idx, input logic [50:0] vpn, input logic [12:0] ctx,
                          input logic [36:0] dat);
    @(negedge clk_i);
    req_valid_i = 1'b0; fsr_clr_i = 1'b0;
    wr_en_i = 1'b1; wr_idx_i = 6'(idx); wr_vpn_i = vpn; wr_ctx_i = ctx; wr_data_i = dat;
    @(posedge clk_i); #1;
    m_vpn[idx] = vpn; m_ctx[idx] = ctx; m_dat[idx] = dat;
  endtask

  task automatic clr_fsr();
    @(negedge clk_i);
    req_valid_i = 1'b0; wr_en_i = 1'b0; fsr_clr_i = 1'b1;
    @(posedge clk_i); #1;
    e_fsr = '0;
  endtask

  task automatic idle();
    @(negedge clk_i);
    req_valid_i = 1'b0; wr_en_i = 1'b0; fsr_clr_i = 1'b0;
  endtask

  task automatic lookup(input logic [63:0] va, input logic [1:0] kind, input logic [1:0] sel,
                        input bit user, input string rq);
    logic [12:0] ctx;
    int hit_i, sh;
    logic [36:0] d;
    bit fp, fs, fn, pr, flt, e_hit, e_miss, e_flt, e_wr;
    logic [40:0] e_pa;
    logic [27:0] lowm;
    logic [9:0] nf;
    string srq;
    ctx = (sel == 2'd0) ? prim_ctx_i : (sel == 2'd1) ? sec_ctx_i : 13'd0;
    hit_i = -1; sh = 0;
    for (int i = 0; i < 64; i++) begin
      int s;
      s = 3 * int'(m_dat[i][35:34]);
      if (hit_i < 0 && m_dat[i][36] &&
          ((va >> 13) >> s) == ({13'b0, m_vpn[i]} >> s) &&
          (m_dat[i][33] || m_ctx[i] == ctx)) begin
        hit_i = i; sh = s;
      end
    end
    fp = 0; fs = 0; fn = 0; pr = 0; e_hit = 0; e_miss = 0; e_flt = 0; e_wr = 0; e_pa = '0;
    d = '0;
    if (!xlate_en_i) begin
      e_hit = 1; e_pa = va[40:0]; e_wr = (kind != 2'd0);
    end else if (hit_i < 0) begin
      e_miss = 1;
    end else begin
      d  = m_dat[hit_i];
      fp = d[32] && user;
      fs = (kind == 2'd3) && d[29];
      fn = (kind == 2'd1 || kind == 2'd2) && d[30];
      pr = !(fp || fs || fn) && kind == 2'd2 && !d[31];
      flt = fp || fs || fn || pr;
      if (flt) e_flt = 1;
      else begin
        e_hit = 1;
        lowm = (28'h1 << sh) - 28'h1;
        e_pa = {(d[27:0] & ~lowm) | (va[40:13] & lowm), 13'b0};
        e_wr = (kind != 2'd0) && d[31];
      end
    end

    @(negedge clk_i);
    req_valid_i = 1'b1; req_va_i = va; req_kind_i = kind; req_ctx_sel_i = sel;
    req_user_i = user; fsr_clr_i = 1'b0;
    wr_en_i = pw_en; wr_idx_i = pw_idx; wr_vpn_i = pw_vpn; wr_ctx_i = pw_ctx; wr_data_i = pw_dat;
    @(posedge clk_i); #1;

    check(rq, 160'({rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_fault_o, rsp_prot_o,
                    rsp_cause_o, rsp_wr_o, rsp_pa_o}),
              160'({1'b1, e_hit, e_miss, e_flt, pr, fn, fs, fp, e_wr, e_pa}));

    if (xlate_en_i) begin
      if (e_hit) m_dat[hit_i][28] = 1'b1;
      if (e_miss || e_flt) e_tag = {va[63:13], ctx};
      if (e_flt) begin
        nf = '0;
        nf[0] = 1'b1; nf[1] = e_fsr[0]; nf[2] = !user; nf[3] = (kind == 2'd2);
        nf[4] = (kind == 2'd3);
        nf[6:5] = (sel == 2'd0) ? 2'd0 : (sel == 2'd1) ? 2'd1 : 2'd2;
        nf[9:7] = {fn, fs, fp};
        e_fsr = nf; e_far = va;
      end
    end
    apply_pending();
    srq = e_flt ? "R11" : e_miss ? "R10" : "R9";
    check(srq, 160'({tag_access_o, fsr_o, far_o}), 160'({e_tag, e_fsr, e_far}));
  endtask

  task automatic probe(input int idx, input string rq);
    @(negedge clk_i);
    req_valid_i = 1'b0; wr_en_i = 1'b0; fsr_clr_i = 1'b0;
    probe_idx_i = 6'(idx);
    #1;
    check(rq, 160'(probe_data_o), 160'(m_dat[idx]));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) begin m_vpn[i] = '0; m_ctx[i] = '0; m_dat[i] = '0; end
    #12;
    // R1: reset state
    check("R1", 160'({rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_fault_o, rsp_prot_o,
                      rsp_cause_o, rsp_wr_o, rsp_pa_o}), 160'(0));
    check("R1", 160'({tag_access_o, fsr_o, far_o}), 160'(0));
    rst_ni = 1'b1;
    idle();

    // R12: bypass
    lookup(64'hFFFF_FF12_3456_789A, 2'd1, 2'd0, 1'b1, "R12");
    lookup(64'h0000_0ABC_DEF0_1234, 2'd0, 2'd1, 1'b0, "R12");
    xlate_en_i = 1'b1;

    // R2: write and lookup in same cycle sees old, next sees new
    prim_ctx_i = 13'd5; sec_ctx_i = 13'd7;
    pw_en = 1'b1; pw_idx = 6'd0; pw_vpn = 51'h12345; pw_ctx = 13'd5;
    pw_dat = mk(1, 2'd0, 0, 0, 1, 0, 0, 28'h00ABC);
    lookup({51'h12345, 13'h010}, 2'd1, 2'd0, 1'b0, "R2");
    lookup({51'h12345, 13'h010}, 2'd1, 2'd0, 1'b0, "R2");
    probe(0, "R8");

    // R5 and R3: overlapping pages of different size
    wr_entry(3, 51'h40000, 13'd1, mk(1, 2'd3, 1, 0, 1, 0, 0, 28'h0001200));
    wr_entry(7, 51'h40001, 13'd1, mk(1, 2'd0, 1, 0, 1, 0, 0, 28'h0000777));
    lookup(64'h0000_0000_8000_2468, 2'd2, 2'd2, 1'b0, "R5");
    wr_entry(9,  51'h50000, 13'd5, mk(1, 2'd1, 0, 0, 0, 0, 0, 28'hFFFFFFF));
    wr_entry(10, 51'h60000, 13'd5, mk(1, 2'd2, 0, 0, 1, 0, 0, 28'hAAAAAAA));
    lookup({51'h50005, 13'h1FFF}, 2'd1, 2'd0, 1'b0, "R3");
    lookup({51'h50008, 13'h0}, 2'd1, 2'd0, 1'b0, "R3");
    lookup({51'h6003F, 13'h0}, 2'd0, 2'd0, 1'b1, "R3");
    lookup({51'h60040, 13'h0}, 2'd0, 2'd0, 1'b1, "R9");

    // R4: context against global
    wr_entry(12, 51'h70000, 13'd7, mk(1, 2'd0, 0, 0, 1, 0, 0, 28'h0000123));
    lookup({51'h70000, 13'h0}, 2'd1, 2'd1, 1'b0, "R4");
    lookup({51'h70000, 13'h0}, 2'd1, 2'd2, 1'b0, "R4");
    lookup({51'h70000, 13'h0}, 2'd1, 2'd0, 1'b0, "R4");

    // R6, R11: combined causes and overflow
    wr_entry(13, 51'h80000, 13'd0, mk(1, 2'd0, 1, 1, 0, 1, 0, 28'h0000321));
    lookup({51'h80000, 13'h4}, 2'd2, 2'd0, 1'b1, "R6");
    lookup({51'h80000, 13'h8}, 2'd1, 2'd1, 1'b1, "R11");
    lookup({51'h80000, 13'h0}, 2'd0, 2'd0, 1'b0, "R6");
    clr_fsr();
    wr_entry(14, 51'h90000, 13'd0, mk(1, 2'd0, 1, 0, 1, 0, 1, 28'h0000444));
    lookup({51'h90000, 13'h0}, 2'd3, 2'd2, 1'b0, "R6");
    lookup({51'h90000, 13'h0}, 2'd1, 2'd2, 1'b0, "R6");
    // R7: protection
    wr_entry(15, 51'hA0000, 13'd0, mk(1, 2'd0, 1, 0, 0, 0, 0, 28'h0000555));
    lookup({51'hA0000, 13'h0}, 2'd2, 2'd0, 1'b0, "R7");
    lookup({51'hA0000, 13'h0}, 2'd1, 2'd0, 1'b0, "R7");
    // R8: used flag, write wins on collision
    probe(15, "R8");
    pw_en = 1'b1; pw_idx = 6'd14; pw_vpn = 51'h90000; pw_ctx = 13'd0;
    pw_dat = mk(1, 2'd0, 1, 0, 1, 0, 1, 28'h0000444);
    lookup({51'h90000, 13'h0}, 2'd1, 2'd2, 1'b0, "R8");
    probe(14, "R8");

    // random phase
    for (int i = 0; i < 64; i++) begin
      logic [50:0] v;
      v = {19'($urandom), 32'($urandom)};
      wr_entry(i, v, 13'($urandom % 4),
               mk(($urandom % 10) != 0, 2'($urandom), ($urandom % 4) == 0,
                  ($urandom % 3) == 0, 1'($urandom), ($urandom % 6) == 0,
                  ($urandom % 5) == 0, 28'($urandom)));
    end
    for (int k = 0; k < 900; k++) begin
      int i;
      logic [63:0] va;
      i = int'($urandom % 64);
      if ($urandom % 8 == 0) va = {$urandom, $urandom};
      else va = {m_vpn[i], 13'h0} ^ (64'($urandom) & 64'h3F_FFFF);
      prim_ctx_i = 13'($urandom % 4);
      sec_ctx_i  = 13'($urandom % 4);
      xlate_en_i = ($urandom % 20) != 0;
      lookup(va, 2'($urandom), 2'($urandom), 1'($urandom), "R6");
      if ($urandom % 7 == 0) clr_fsr();
      if ($urandom % 15 == 0)
        wr_entry(int'($urandom % 64), {19'($urandom), 32'($urandom)}, 13'($urandom % 4),
                 mk(1, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom), 28'($urandom)));
    end
    for (int i = 0; i < 64; i++) probe(i, "R8");
    idle();
    @(posedge clk_i); #1;
    check("R1", 160'({rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_fault_o}), 160'(0));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule